// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the power-mode state machine of a small microcontroller. It holds one of seven operating modes: normal active, low-power active, idle, low-power idle, stop, suspend and sleep. Software selects a mode by presenting a mode code with a one-cycle write strobe. The block then drives the CPU halt, the system clock enable, the per-peripheral clock enables, the main oscillator enable, the real-time-clock oscillator enable and the core power gate.

While the CPU is halted, the block watches the wake inputs. Each mode has its own set of wake sources. The block brings the core back to an active mode with the right timing. Idle modes resume after a fixed short latency. Suspend first restarts the oscillator and waits for it to be ready. Sleep first restores power and waits for power-good and oscillator-ready. Stop can be left only through the reset pin. The reset pin resets the core from any mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_n` is released, `cur_mode` is 0 (normal active) and the outputs are as follows: `cpu_halt`=0, `sys_clk_en`=1, `osc_en`=1, `pwr_gate`=0, `rst_out`=0, and every bit of `periph_clk_en` is 1.
- R2: The mode codes are 0 normal active, 1 low-power active, 2 idle, 3 low-power idle, 4 stop, 5 suspend and 6 sleep. Code 7 is ignored. While running, a write of 0 or 1 changes `cur_mode` at the next clock edge, and the CPU keeps running.
- R3: In modes 0 and 2, all peripheral clocks are enabled. In modes 1 and 3, `periph_clk_en` equals `periph_clk_req`. While the system clock is off, all peripheral clocks are off.
- R4: A write of 2 or 3 raises `cpu_halt` at the next edge. If `irq` is high in a cycle while the CPU is halted in one of these modes, `cpu_halt` falls at the second clock edge after that cycle. Mode 2 then returns to mode 0, and mode 3 returns to mode 1.
- R5: Stop (4) sets `cpu_halt`=1, `sys_clk_en`=0 and `osc_en`=0. `irq`, `wake_touch`, `wake_rtc`, `wake_port` and `wake_i2c` have no effect in stop. Only `rst_pin` leaves stop.
- R6: Suspend (5) sets `sys_clk_en`=0 and `osc_en`=0 and ignores `irq`. Any of `wake_touch`, `wake_rtc`, `wake_port` or `wake_i2c` raises `osc_en` first. `sys_clk_en` rises and `cpu_halt` falls only at the edge that samples `osc_ready` high. The block then returns to the active mode it held before.
- R7: Sleep (6) sets `pwr_gate`=1 and `osc_en`=0 and keeps `rtc_osc_en`=1. Only `wake_rtc`, `wake_port` or `wake_i2c` wake it; `wake_touch` and `irq` are ignored. On wake, `pwr_gate` falls and `osc_en` rises. The CPU is released only at the edge that samples both `pwr_good` and `osc_ready` high.
- R8: A mode write is ignored while `cpu_halt` is high, and `cur_mode` stays unchanged.
- R9: `rst_pin` high at an edge raises `rst_out` from any mode. `rst_out` holds while `rst_pin` stays high. After `rst_pin` goes low, the block returns to mode 0 once `osc_ready` and `pwr_good` are both high.
- R10: A write that requests idle, low-power idle, suspend or sleep is cancelled if one of that mode's wake sources is high in the same cycle. The block keeps running in its current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the controller |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_valid | input | 1 | One-cycle strobe of a mode write |
| req_mode | input | 3 | Requested mode code |
| irq | input | 1 | Any enabled interrupt pending |
| wake_touch | input | 1 | Touch-sense event |
| wake_rtc | input | 1 | Real-time-clock alarm |
| wake_port | input | 1 | Port-match event |
| wake_i2c | input | 1 | I2C slave address match |
| rst_pin | input | 1 | External reset pin, active high |
| osc_ready | input | 1 | Main oscillator is stable |
| pwr_good | input | 1 | Core power domain is up |
| periph_clk_req | input | NUM_PERIPH | Per-peripheral clock requests |
| cur_mode | output | 3 | Current mode code (status) |
| cpu_halt | output | 1 | Holds the CPU from executing |
| sys_clk_en | output | 1 | System clock enable |
| osc_en | output | 1 | Main oscillator enable |
| rtc_osc_en | output | 1 | Real-time-clock oscillator enable |
| pwr_gate | output | 1 | Removes power from the core domain |
| rst_out | output | 1 | Full reset to the core |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |

## Verification
Each low-power mode is entered and then driven with every wake input in turn. This separates the sources that belong to the mode from those it must ignore: a touch event in sleep, an interrupt in suspend, and everything except the pin in stop. The bench changes the clock-request pattern while the block is in low-power active and in low-power idle. This shows whether the enables follow the requests or are forced on. The bench holds `osc_ready` and `pwr_good` low across several cycles. This shows whether the CPU is released early. It also checks same-cycle wake-and-request pairs and writes made while halted. These separate a cancelled entry from an entry that is ignored.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      PM_ACTIVE    = 3'd0,
      PM_LP_ACTIVE = 3'd1,
      PM_IDLE      = 3'd2,
      PM_LP_IDLE   = 3'd3,
      PM_STOP      = 3'd4,
      PM_SUSPEND   = 3'd5,
      PM_SLEEP     = 3'd6,
      PM_RSVD      = 3'd7
   } pm_mode_e;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_HALT,
      ST_IDLE_WAKE,
      ST_CLK_WAIT,
      ST_PWR_WAIT,
      ST_RST
   } pm_state_e;

   typedef struct packed {
      logic irq;
      logic touch;
      logic rtc;
      logic port;
      logic i2c;
   } pm_wake_s;

   function automatic logic pm_is_deep(pm_mode_e m);
      return (m == PM_STOP) || (m == PM_SUSPEND) || (m == PM_SLEEP);
   endfunction

endpackage

// File: rtl/pwr_wake_decode.sv
module pwr_wake_decode
   import pwr_mode_pkg::*;
(
   input  pm_mode_e mode,
   input  pm_wake_s wake,
   output logic     hit
);
   always_comb begin
      unique case (mode)
         PM_IDLE, PM_LP_IDLE: hit = wake.irq;
         PM_SUSPEND:          hit = wake.touch | wake.rtc | wake.port | wake.i2c;
         PM_SLEEP:            hit = wake.rtc | wake.port | wake.i2c;
         default:             hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate #(
   parameter int NUM_PERIPH = 8
) (
   input  logic                  sys_clk_en,
   input  logic                  lp_class,
   input  logic [NUM_PERIPH-1:0] clk_req,
   output logic [NUM_PERIPH-1:0] clk_en
);
   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_lane
      assign clk_en[i] = sys_clk_en & (~lp_class | clk_req[i]);
   end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter int WAKE_CYCLES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  pm_mode_e req_mode,
   input  logic     entry_abort,
   input  logic     halt_wake,
   input  logic     rst_pin,
   input  logic     osc_ready,
   input  logic     pwr_good,
   output pm_mode_e mode_q,
   output logic     cpu_halt,
   output logic     sys_clk_en,
   output logic     osc_en,
   output logic     pwr_gate,
   output logic     rst_out,
   output logic     lp_class
);
   localparam int CNT_W   = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES - 1) : 1;
   localparam int CNT_TOP = WAKE_CYCLES - 2;

   pm_state_e  state_q, state_d;
   pm_mode_e   mode_d, run_q, run_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      mode_d  = mode_q;
      run_d   = run_q;
      cnt_d   = cnt_q;
      if (rst_pin) begin
         state_d = ST_RST;
         mode_d  = PM_ACTIVE;
         run_d   = PM_ACTIVE;
      end else begin
         unique case (state_q)
            ST_RUN: if (req_valid) begin
               if (req_mode == PM_ACTIVE || req_mode == PM_LP_ACTIVE) begin
                  mode_d = req_mode;
                  run_d  = req_mode;
               end else if (req_mode != PM_RSVD && !entry_abort) begin
                  state_d = ST_HALT;
                  mode_d  = req_mode;
                  if (req_mode == PM_IDLE)    run_d = PM_ACTIVE;
                  if (req_mode == PM_LP_IDLE) run_d = PM_LP_ACTIVE;
               end
            end
            ST_HALT: if (halt_wake) begin
               if (mode_q == PM_SUSPEND)    state_d = ST_CLK_WAIT;
               else if (mode_q == PM_SLEEP) state_d = ST_PWR_WAIT;
               else begin
                  state_d = ST_IDLE_WAKE;
                  cnt_d   = CNT_W'(CNT_TOP);
               end
            end
            ST_IDLE_WAKE: begin
               if (cnt_q == '0) begin
                  state_d = ST_RUN;
                  mode_d  = run_q;
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            ST_CLK_WAIT: if (osc_ready) begin
               state_d = ST_RUN;
               mode_d  = run_q;
            end
            ST_PWR_WAIT: if (osc_ready && pwr_good) begin
               state_d = ST_RUN;
               mode_d  = run_q;
            end
            ST_RST: if (osc_ready && pwr_good) begin
               state_d = ST_RUN;
               mode_d  = PM_ACTIVE;
            end
            default: state_d = ST_RST;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         mode_q  <= PM_ACTIVE;
         run_q   <= PM_ACTIVE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         mode_q  <= mode_d;
         run_q   <= run_d;
         cnt_q   <= cnt_d;
      end
   end

   logic deep_halt;
   assign deep_halt  = (state_q == ST_HALT) && pm_is_deep(mode_q);
   assign cpu_halt   = (state_q != ST_RUN);
   assign sys_clk_en = !(deep_halt || state_q == ST_CLK_WAIT || state_q == ST_PWR_WAIT);
   assign osc_en     = !deep_halt;
   assign pwr_gate   = (state_q == ST_HALT) && (mode_q == PM_SLEEP);
   assign rst_out    = (state_q == ST_RST);
   assign lp_class   = (mode_q == PM_LP_ACTIVE) || (mode_q == PM_LP_IDLE);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_mode_pkg::*;
#(
   parameter int NUM_PERIPH  = 8,
   parameter int WAKE_CYCLES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [2:0]            req_mode,
   input  logic                  irq,
   input  logic                  wake_touch,
   input  logic                  wake_rtc,
   input  logic                  wake_port,
   input  logic                  wake_i2c,
   input  logic                  rst_pin,
   input  logic                  osc_ready,
   input  logic                  pwr_good,
   input  logic [NUM_PERIPH-1:0] periph_clk_req,
   output logic [2:0]            cur_mode,
   output logic                  cpu_halt,
   output logic                  sys_clk_en,
   output logic                  osc_en,
   output logic                  rtc_osc_en,
   output logic                  pwr_gate,
   output logic                  rst_out,
   output logic [NUM_PERIPH-1:0] periph_clk_en
);
   if (NUM_PERIPH < 1) begin : g_bad_np
      $error("pwr_mode_seq: NUM_PERIPH must be at least 1");
   end
   if (WAKE_CYCLES < 2) begin : g_bad_wake
      $error("pwr_mode_seq: WAKE_CYCLES must be at least 2");
   end

   pm_wake_s wake;
   pm_mode_e req_e, mode_q;
   logic     entry_abort, halt_wake, lp_class;

   assign wake  = '{irq: irq, touch: wake_touch, rtc: wake_rtc,
                    port: wake_port, i2c: wake_i2c};
   assign req_e = pm_mode_e'(req_mode);

   pwr_wake_decode u_abort_dec (.mode(req_e),  .wake(wake), .hit(entry_abort));
   pwr_wake_decode u_halt_dec  (.mode(mode_q), .wake(wake), .hit(halt_wake));

   pwr_mode_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_mode   (req_e),
      .entry_abort(entry_abort),
      .halt_wake  (halt_wake),
      .rst_pin    (rst_pin),
      .osc_ready  (osc_ready),
      .pwr_good   (pwr_good),
      .mode_q     (mode_q),
      .cpu_halt   (cpu_halt),
      .sys_clk_en (sys_clk_en),
      .osc_en     (osc_en),
      .pwr_gate   (pwr_gate),
      .rst_out    (rst_out),
      .lp_class   (lp_class)
   );

   pwr_clk_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
      .sys_clk_en(sys_clk_en),
      .lp_class  (lp_class),
      .clk_req   (periph_clk_req),
      .clk_en    (periph_clk_en)
   );

   assign cur_mode   = mode_q;
   assign rtc_osc_en = 1'b1;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
   parameter int NUM_PERIPH = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [2:0]            req_mode,
   input logic                  irq,
   input logic                  rst_pin,
   input logic                  osc_ready,
   input logic                  pwr_good,
   input logic [NUM_PERIPH-1:0] periph_clk_req,
   input logic [2:0]            cur_mode,
   input logic                  cpu_halt,
   input logic                  sys_clk_en,
   input logic                  osc_en,
   input logic                  rtc_osc_en,
   input logic                  pwr_gate,
   input logic                  rst_out,
   input logic [NUM_PERIPH-1:0] periph_clk_en
);
   AST_PIN_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pin |=> rst_out); // R9
   AST_FULL_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd0 && !cpu_halt) |-> (&periph_clk_en)); // R3
   AST_LP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd1 && !cpu_halt) |-> (periph_clk_en == periph_clk_req)); // R3
   AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd4 && !rst_pin) |=> (cur_mode == 3'd4 && cpu_halt)); // R5
   AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_halt) && ($past(cur_mode) == 3'd2 || $past(cur_mode) == 3'd3))
      |-> $past(irq, 2)); // R4
   AST_CLOCK_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sys_clk_en) && !rst_out) |-> ($past(osc_ready) && $past(pwr_good))); // R6
   AST_SLEEP_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_gate |-> (rtc_osc_en && !osc_en && cpu_halt)); // R7
   AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cpu_halt && !rst_pin && irq && req_mode == 3'd2)
      |=> !cpu_halt); // R10
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (.*);

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/100ps
module pwr_mode_seq_test;
   localparam int NP = 8;
   localparam logic [NP-1:0] ALL = '1;
   localparam logic [2:0] ACT = 3'd0, LPA = 3'd1, IDL = 3'd2, LPI = 3'd3,
                          STP = 3'd4, SUS = 3'd5, SLP = 3'd6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [2:0] req_mode = 3'd0;
   logic irq = 1'b0, wake_touch = 1'b0, wake_rtc = 1'b0, wake_port = 1'b0, wake_i2c = 1'b0;
   logic rst_pin = 1'b0, osc_ready = 1'b1, pwr_good = 1'b1;
   logic [NP-1:0] periph_clk_req = '0;
   logic [2:0] cur_mode;
   logic cpu_halt, sys_clk_en, osc_en, rtc_osc_en, pwr_gate, rst_out;
   logic [NP-1:0] periph_clk_en;

   always #2 clk = ~clk;

   pwr_mode_seq #(.NUM_PERIPH(NP)) uut (.*);

   typedef struct {
      string         tag;
      logic [2:0]    mode;
      logic          halt, sclk, osc, pg, rst;
      logic [NP-1:0] pclk;
   } exp_t;

   exp_t sb[$];
   exp_t cur;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         cur = sb.pop_front();
         checks++;
         if (cur_mode !== cur.mode || cpu_halt !== cur.halt || sys_clk_en !== cur.sclk ||
             osc_en !== cur.osc || pwr_gate !== cur.pg || rst_out !== cur.rst ||
             periph_clk_en !== cur.pclk || rtc_osc_en !== 1'b1) begin
            fails++;
            $display("FAIL %s: got mode=%0d halt=%b sclk=%b osc=%b pg=%b rst=%b pclk=%h rtc=%b, expected mode=%0d halt=%b sclk=%b osc=%b pg=%b rst=%b pclk=%h rtc=1",
                     cur.tag, cur_mode, cpu_halt, sys_clk_en, osc_en, pwr_gate, rst_out,
                     periph_clk_en, rtc_osc_en, cur.mode, cur.halt, cur.sclk, cur.osc,
                     cur.pg, cur.rst, cur.pclk);
         end
      end
   end

   task automatic step(input string tag, input logic [2:0] m, input logic h, input logic s,
                       input logic o, input logic p, input logic r, input logic [NP-1:0] pc);
      exp_t e;
      e.tag = tag; e.mode = m; e.halt = h; e.sclk = s; e.osc = o; e.pg = p; e.rst = r; e.pclk = pc;
      @(posedge clk);
      #1 sb.push_back(e);
      @(negedge clk);
      #1;
      req_valid = 1'b0; irq = 1'b0; wake_touch = 1'b0; wake_rtc = 1'b0;
      wake_port = 1'b0; wake_i2c = 1'b0;
   endtask

   task automatic write_mode(input logic [2:0] m);
      req_valid = 1'b1;
      req_mode  = m;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      step("R1 reset state", ACT, 0, 1, 1, 0, 0, ALL);

      periph_clk_req = 8'h05; write_mode(LPA);
      step("R2 write low-power active", LPA, 0, 1, 1, 0, 0, 8'h05);
      periph_clk_req = 8'h30;
      step("R3 lp active follows requests", LPA, 0, 1, 1, 0, 0, 8'h30);
      write_mode(3'd7);
      step("R2 reserved code ignored", LPA, 0, 1, 1, 0, 0, 8'h30);
      write_mode(LPI);
      step("R4 enter low-power idle", LPI, 1, 1, 1, 0, 0, 8'h30);
      periph_clk_req = 8'h81; write_mode(ACT);
      step("R8 write while halted ignored", LPI, 1, 1, 1, 0, 0, 8'h81);
      irq = 1'b1;
      step("R4 first cycle after irq still halted", LPI, 1, 1, 1, 0, 0, 8'h81);
      step("R4 lp idle resumes into lp active", LPA, 0, 1, 1, 0, 0, 8'h81);
      write_mode(ACT);
      step("R3 normal active forces all clocks", ACT, 0, 1, 1, 0, 0, ALL);
      write_mode(IDL); irq = 1'b1;
      step("R10 idle entry cancelled by irq", ACT, 0, 1, 1, 0, 0, ALL);
      write_mode(IDL);
      step("R4 enter idle", IDL, 1, 1, 1, 0, 0, ALL);
      irq = 1'b1;
      step("R4 idle wake latency 1", IDL, 1, 1, 1, 0, 0, ALL);
      step("R4 idle resumes into active", ACT, 0, 1, 1, 0, 0, ALL);

      write_mode(SUS);
      step("R6 enter suspend", SUS, 1, 0, 0, 0, 0, '0);
      osc_ready = 1'b0; irq = 1'b1;
      step("R6 irq ignored in suspend", SUS, 1, 0, 0, 0, 0, '0);
      wake_port = 1'b1;
      step("R6 port match starts oscillator", SUS, 1, 0, 1, 0, 0, '0);
      step("R6 waits for oscillator ready", SUS, 1, 0, 1, 0, 0, '0);
      osc_ready = 1'b1;
      step("R6 release after oscillator ready", ACT, 0, 1, 1, 0, 0, ALL);
      write_mode(SUS); wake_rtc = 1'b1;
      step("R10 suspend entry cancelled by alarm", ACT, 0, 1, 1, 0, 0, ALL);

      write_mode(SLP);
      step("R7 enter sleep", SLP, 1, 0, 0, 1, 0, '0);
      pwr_good = 1'b0; osc_ready = 1'b0; wake_touch = 1'b1; irq = 1'b1;
      step("R7 touch and irq ignored in sleep", SLP, 1, 0, 0, 1, 0, '0);
      wake_i2c = 1'b1;
      step("R7 i2c match restores power", SLP, 1, 0, 1, 0, 0, '0);
      pwr_good = 1'b1;
      step("R7 waits for oscillator too", SLP, 1, 0, 1, 0, 0, '0);
      osc_ready = 1'b1;
      step("R7 release after power and oscillator", ACT, 0, 1, 1, 0, 0, ALL);

      write_mode(STP);
      step("R5 enter stop", STP, 1, 0, 0, 0, 0, '0);
      irq = 1'b1; wake_touch = 1'b1; wake_rtc = 1'b1; wake_port = 1'b1; wake_i2c = 1'b1;
      step("R5 wake inputs ignored in stop", STP, 1, 0, 0, 0, 0, '0);
      rst_pin = 1'b1;
      step("R9 reset pin leaves stop", ACT, 1, 1, 1, 0, 1, ALL);
      step("R9 reset held while pin high", ACT, 1, 1, 1, 0, 1, ALL);
      rst_pin = 1'b0;
      step("R9 return to active after pin", ACT, 0, 1, 1, 0, 0, ALL);

      write_mode(SLP);
      step("R7 enter sleep again", SLP, 1, 0, 0, 1, 0, '0);
      rst_pin = 1'b1;
      step("R9 reset pin from sleep", ACT, 1, 1, 1, 0, 1, ALL);
      rst_pin = 1'b0;
      step("R9 active after sleep reset", ACT, 0, 1, 1, 0, 0, ALL);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule